// File: doc/BRIEF.md
# Two-Wire Bus Slave with Pin-Selected Address

This block is a slave on a two-wire serial bus (I2C). It answers to one 7-bit address out of four, picked by a 2-bit select input that stands in for an external address-strap decode. The upper five address bits are a build-time parameter. The lower two address bits come from the select input.

When the direction bit of the address byte is 0, the master writes. The slave acknowledges each data byte and stores the bytes one after another into a small bank of control registers, which is exposed as a flat output. When the direction bit is 1, the master reads. The slave returns status bytes, taken from a parallel status input, for as long as the master acknowledges them. A master that fails to acknowledge ends the transfer inside the slave: the slave behaves as if a STOP had been seen and drives nothing more until the next START.

Both bus lines are oversampled by the system clock. The slave pulls SDA low through an open-drain enable and never drives it high.

Top module: `i2c_addr_slave`

## Requirements
- R1: The slave address is {ADDR_HI, addr_sel_i}, with addr_sel_i in bits 1:0. When the first 7 bits after a START match this address, the slave holds sda_oe_o high (SDA low) for the whole acknowledge clock. A change of addr_sel_i moves the slave to the new address.
- R2: If the address does not match, the slave does not acknowledge. It then ignores all bus activity until the next START, and the registers keep their values.
- R3: The address byte is sent MSB first, and its bit 0 is the direction: 0 means write. In a write transfer, every data byte is acknowledged. The bytes are stored at register indices 0, 1, 2, and so on. Register k appears on ctrl_regs_o[8k+7:8k].
- R4: The write index stops at NUM_REGS-1. Any further bytes in the same transfer are acknowledged and overwrite the last register.
- R5: Direction bit 1 means read. The slave returns status byte 0 first, taken from status_i[7:0], sent MSB first. After each master acknowledge (SDA low in the acknowledge slot), it returns the next byte (status_i[8k+7:8k]). The index stops at NUM_STAT-1, so the last byte is repeated.
- R6: If the master does not acknowledge during a read, the slave releases SDA and drives no further data on any later clock until a new START.
- R7: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. After a STOP the slave is idle and ignores clocked bytes.
- R8: A repeated START, with no STOP before it, returns the slave to the address phase, and the new direction bit applies.
- R9: sda_oe_o changes only while SCL is low. Incoming bits are sampled on the SCL rising edge.
- R10: During and after reset, sda_oe_o is 0 and all control registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_sel_i | input | 2 | Selects the low two address bits |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| status_i | input | NUM_STAT*8 | Status bytes returned on reads, byte k at bits 8k+7:8k |
| ctrl_regs_o | output | NUM_REGS*8 | Control register bank, register k at bits 8k+7:8k |

## Verification
The bench builds the block with ADDR_HI = 5'b10100, NUM_REGS = 4 and NUM_STAT = 2. With only four registers, a single six-byte write is enough to reach write-index saturation and overwrite the last register. With two status bytes, a three-byte read shows that the last status byte repeats. Two select values are used, so the bench sees the old address stop working and the new one start. The open-drain bus is modelled as a wired AND of master and slave, so a missing acknowledge and a released line are seen exactly as a master would see them.

// File: rtl/i2c_slv_pkg.sv
// Package: shared types for the two-wire bus slave.
// Assumes: nothing beyond standard SystemVerilog.
package i2c_slv_pkg;

    // Protocol phases of the slave
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,  // waiting for START
        ST_ADDR     = 3'd1,  // shifting in address byte
        ST_ADDR_ACK = 3'd2,  // driving address acknowledge
        ST_WR_DATA  = 3'd3,  // shifting in a write byte
        ST_WR_ACK   = 3'd4,  // driving write acknowledge
        ST_RD_DATA  = 3'd5,  // driving a status byte
        ST_RD_ACK   = 3'd6,  // sampling master acknowledge
        ST_HALT     = 3'd7   // internal stop after a master NACK
    } slv_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the clock domain through two flip-flops each.
// Derives clock edges and START/STOP events from the synchronized values.
// Assumes: the system clock is several times faster than SCL, and both
// lines idle high.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] meta_q;
    logic [1:0] sync_q;
    logic [1:0] prev_q;

    // Purpose: two-stage synchronizer plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 2'b11;
            sync_q <= 2'b11;
            prev_q <= 2'b11;
        end else begin
            meta_q <= {scl_i, sda_i};
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: decode edges and bus conditions from current and previous values.
    always_comb begin
        scl_s     = sync_q[1];
        sda_s     = sync_q[0];
        scl_rise  = sync_q[1] & ~prev_q[1];
        scl_fall  = ~sync_q[1] & prev_q[1];
        start_det = sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
        stop_det  = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];
    end

endmodule

// File: rtl/i2c_reg_bank.sv
// Module: i2c_reg_bank
// Control registers written one after another from index 0.
// The write index saturates at the last register.
// Assumes: clr_idx and wr_en are never high in the same cycle.
module i2c_reg_bank #(
    parameter int NUM_REGS = 4,
    parameter int WI_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_idx,
    input  logic                  wr_en,
    input  logic [7:0]            wr_data,
    output logic [WI_W-1:0]       wr_idx,
    output logic [NUM_REGS*8-1:0] regs_o
);

    localparam logic [WI_W-1:0] LAST_IDX = WI_W'(NUM_REGS - 1);

    // Purpose: restart at 0 on a new write transfer, else step up and saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
        end else if (clr_idx) begin
            wr_idx <= '0;
        end else if (wr_en && (wr_idx != LAST_IDX)) begin
            wr_idx <= wr_idx + WI_W'(1);
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] reg_q;

        // Purpose: load this register when the index points at it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q <= '0;
            end else if (wr_en && (wr_idx == WI_W'(g))) begin
                reg_q <= wr_data;
            end
        end

        assign regs_o[g*8 +: 8] = reg_q;
    end

endmodule

// File: rtl/i2c_slv_fsm.sv
// Module: i2c_slv_fsm
// Protocol engine: address compare, write acknowledge, status read-out,
// and the internal stop after a master NACK.
// Assumes: events come from i2c_line_sync. SDA is changed only on an SCL
// falling-edge event, and data is sampled on an SCL rising-edge event.
module i2c_slv_fsm
    import i2c_slv_pkg::*;
#(
    parameter int NUM_STAT = 2,
    parameter int RI_W     = (NUM_STAT > 1) ? $clog2(NUM_STAT) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [6:0]            own_addr,
    input  logic [NUM_STAT*8-1:0] status_i,
    output logic                  sda_oe,
    output logic                  wr_pulse,
    output logic [7:0]            wr_byte,
    output logic                  wr_restart,
    output slv_state_t            state
);

    localparam logic [RI_W-1:0] LAST_RD = RI_W'(NUM_STAT - 1);

    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [RI_W-1:0] rd_idx;
    logic [RI_W-1:0] rd_next;
    logic            is_read;
    logic            mack;
    logic [7:0]      stat_first;
    logic [7:0]      stat_next;

    // Purpose: next read index (saturating) and the status bytes to load.
    always_comb begin
        rd_next    = (rd_idx == LAST_RD) ? rd_idx : rd_idx + RI_W'(1);
        stat_first = status_i[8*int'(rd_idx) +: 8];
        stat_next  = status_i[8*int'(rd_next) +: 8];
    end

    // Purpose: protocol state machine; START and STOP override every phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            rd_idx     <= '0;
            is_read    <= 1'b0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
            wr_pulse   <= 1'b0;
            wr_byte    <= '0;
            wr_restart <= 1'b0;
        end else begin
            wr_pulse   <= 1'b0;
            wr_restart <= 1'b0;
            if (start_det) begin
                state  <= ST_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && (bitcnt == 4'd8)) begin
                            if (shreg[7:1] == own_addr) begin
                                state      <= ST_ADDR_ACK;
                                sda_oe     <= 1'b1;
                                is_read    <= shreg[0];
                                rd_idx     <= '0;
                                wr_restart <= ~shreg[0];
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (is_read) begin
                                shreg  <= stat_first;
                                sda_oe <= ~stat_first[7];
                                state  <= ST_RD_DATA;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR_DATA;
                            end
                        end
                    end
                    ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && (bitcnt == 4'd8)) begin
                            wr_pulse <= 1'b1;
                            wr_byte  <= shreg;
                            sda_oe   <= 1'b1;
                            state    <= ST_WR_ACK;
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            state  <= ST_WR_DATA;
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                rd_idx <= rd_next;
                                shreg  <= stat_next;
                                sda_oe <= ~stat_next[7];
                                bitcnt <= '0;
                                state  <= ST_RD_DATA;
                            end else begin
                                state <= ST_HALT;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_addr_slave.sv
// Module: i2c_addr_slave
// Top level of the two-wire bus slave with a pin-selected address.
// Assumes: sda_i carries the wired bus value, including the slave's own pull.
// The pad's open-drain buffer is driven from sda_oe_o.
module i2c_addr_slave
    import i2c_slv_pkg::*;
#(
    parameter logic [4:0] ADDR_HI  = 5'b10100,
    parameter int         NUM_REGS = 4,
    parameter int         NUM_STAT = 2,
    parameter int         WI_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            addr_sel_i,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    input  logic [NUM_STAT*8-1:0] status_i,
    output logic [NUM_REGS*8-1:0] ctrl_regs_o
);

    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       wr_pulse;
    logic       wr_restart;
    logic [7:0] wr_byte;
    logic [WI_W-1:0] wr_idx;
    logic [6:0] own_addr;
    slv_state_t state;

    assign own_addr = {ADDR_HI, addr_sel_i};

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_slv_fsm #(.NUM_STAT(NUM_STAT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .own_addr   (own_addr),
        .status_i   (status_i),
        .sda_oe     (sda_oe_o),
        .wr_pulse   (wr_pulse),
        .wr_byte    (wr_byte),
        .wr_restart (wr_restart),
        .state      (state)
    );

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .WI_W(WI_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_idx (wr_restart),
        .wr_en   (wr_pulse),
        .wr_data (wr_byte),
        .wr_idx  (wr_idx),
        .regs_o  (ctrl_regs_o)
    );

endmodule

// File: rtl/i2c_addr_slave_chk.sv
// Module: i2c_addr_slave_chk
// Protocol assertions for i2c_addr_slave, attached with bind.
// Assumes: the internal names of the top module used in the bind below.
module i2c_addr_slave_chk
    import i2c_slv_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int WI_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scl_s,
    input logic            sda_oe_o,
    input logic            wr_pulse,
    input logic [WI_W-1:0] wr_idx,
    input slv_state_t      state
);

    localparam logic [WI_W-1:0] LAST_IDX = WI_W'(NUM_REGS - 1);

    // R9: the open-drain enable moves only on an edge where SCL was seen low
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !$past(scl_s));

    // R1: the acknowledge phase after a matching address pulls SDA low
    a_r1_ack_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> sda_oe_o);

    // R2: an idle slave never pulls the line
    a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R6: after a master NACK the line stays released
    a_r6_halt_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> !sda_oe_o);

    // R3: every stored byte comes with an acknowledge
    a_r3_store_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> (sda_oe_o && (state == ST_WR_ACK)));

    // R4: a write at the last index leaves the index there
    a_r4_idx_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && (wr_idx == LAST_IDX)) |=> (wr_idx == LAST_IDX));

endmodule

bind i2c_addr_slave i2c_addr_slave_chk #(.NUM_REGS(NUM_REGS), .WI_W(WI_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe_o (sda_oe_o),
    .wr_pulse (wr_pulse),
    .wr_idx   (wr_idx),
    .state    (state)
);

// File: tb/i2c_addr_slave_tb.sv
// Bench for i2c_addr_slave. A bus master drives the lines. Driver tasks
// push expected items into a queue, and a monitor process pops and
// compares them.
module i2c_addr_slave_tb;

    localparam logic [4:0] ADDR_HI  = 5'b10100;
    localparam int         NUM_REGS = 4;
    localparam int         NUM_STAT = 2;
    localparam int         Q        = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic sda_oe;
    logic [NUM_STAT*8-1:0] status = {8'hC3, 8'h5A};
    logic [NUM_REGS*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_addr_slave #(.ADDR_HI(ADDR_HI), .NUM_REGS(NUM_REGS), .NUM_STAT(NUM_STAT)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_sel_i  (addr_sel),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .status_i    (status),
        .ctrl_regs_o (regs)
    );

    int checks = 0;
    int errors = 0;
    int viol   = 0;
    bit done   = 1'b0;
    logic oe_prev = 1'b0;
    string req_q[$];
    logic [31:0] val_q[$];
    logic [31:0] obs_val;
    event obs_ev;
    logic [NUM_REGS*8-1:0] exp_regs = '0;
    int widx = 0;

    // Monitor: pop the next expected item and compare it with the observation
    initial begin
        forever begin
            @(obs_ev);
            checks++;
            if (req_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected observation actual=%0h expected=none", obs_val);
            end else begin
                string r;
                logic [31:0] e;
                r = req_q.pop_front();
                e = val_q.pop_front();
                if (obs_val !== e) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", r, obs_val, e);
                end
            end
        end
    end

    // R9 watcher: the enable must not move while the master holds SCL high
    always @(negedge clk) begin
        if (rst_n && (sda_oe != oe_prev) && scl_m) viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] exp, input logic [31:0] act);
        req_q.push_back(req);
        val_q.push_back(exp);
        obs_val = act;
        -> obs_ev;
        @(negedge clk);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    hold(Q);
        scl_m = 1'b1; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q/2);
        b = sda_bus;  hold(Q/2);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic acked);
        logic x;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        get_bit(x);
        acked = ~x;
    endtask

    task automatic get_byte(output logic [7:0] b, input logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            b[i] = x;
        end
        put_bit(~ack);
    endtask

    task automatic model_write(input logic [7:0] b);
        exp_regs[widx*8 +: 8] = b;
        if (widx < NUM_REGS - 1) widx++;
    endtask

    function automatic logic [7:0] addr_byte(input logic [1:0] sel, input logic rw);
        return {ADDR_HI, sel, rw};
    endfunction

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;

        // R10: reset state
        hold(5);
        chk("R10 oe in reset", 0, 32'(sda_oe));
        rst_n = 1'b1;
        hold(5);
        chk("R10 oe after reset", 0, 32'(sda_oe));
        chk("R10 regs after reset", 0, regs);

        // R1/R3: matching write of three bytes
        bus_start();
        put_byte(addr_byte(2'b01, 1'b0), ack);
        chk("R1 address ack", 1, 32'(ack));
        widx = 0;
        put_byte(8'h11, ack); model_write(8'h11); chk("R3 byte0 ack", 1, 32'(ack));
        put_byte(8'hA2, ack); model_write(8'hA2); chk("R3 byte1 ack", 1, 32'(ack));
        put_byte(8'h7E, ack); model_write(8'h7E); chk("R3 byte2 ack", 1, 32'(ack));
        bus_stop();
        hold(4);
        chk("R3 regs stored", exp_regs, regs);

        // R4: six bytes saturate on the last register
        bus_start();
        put_byte(addr_byte(2'b01, 1'b0), ack);
        chk("R4 address ack", 1, 32'(ack));
        widx = 0;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            d = 8'(8'h20 + i);
            put_byte(d, ack);
            model_write(d);
            chk("R4 data ack", 1, 32'(ack));
        end
        bus_stop();
        hold(4);
        chk("R4 regs saturated", exp_regs, regs);

        // R2: wrong address not acked, following byte ignored
        bus_start();
        put_byte(addr_byte(2'b11, 1'b0), ack);
        chk("R2 mismatch nack", 0, 32'(ack));
        put_byte(8'hFF, ack);
        chk("R2 byte after mismatch nack", 0, 32'(ack));
        bus_stop();
        hold(4);
        chk("R2 regs unchanged", exp_regs, regs);

        // R1: select change moves the address
        addr_sel = 2'b10;
        hold(4);
        bus_start();
        put_byte(addr_byte(2'b01, 1'b1), ack);
        chk("R1 old address nack", 0, 32'(ack));
        bus_stop();
        bus_start();
        put_byte(addr_byte(2'b10, 1'b1), ack);
        chk("R1 new address ack", 1, 32'(ack));

        // R5: read with acks, last byte repeats
        get_byte(rb, 1'b1); chk("R5 status byte0", 32'h5A, 32'(rb));
        get_byte(rb, 1'b1); chk("R5 status byte1", 32'hC3, 32'(rb));
        get_byte(rb, 1'b0); chk("R5 status saturate", 32'hC3, 32'(rb));

        // R6: after NACK nothing is driven
        get_byte(rb, 1'b0);
        chk("R6 released after nack", 32'hFF, 32'(rb));
        chk("R6 oe low after nack", 0, 32'(sda_oe));
        bus_stop();

        // R8: repeated start switches write to read
        bus_start();
        put_byte(addr_byte(2'b10, 1'b0), ack);
        chk("R8 write address ack", 1, 32'(ack));
        widx = 0;
        put_byte(8'h3C, ack); model_write(8'h3C);
        chk("R8 data ack", 1, 32'(ack));
        bus_start();
        put_byte(addr_byte(2'b10, 1'b1), ack);
        chk("R8 read address ack after repeated start", 1, 32'(ack));
        get_byte(rb, 1'b0);
        chk("R8 status byte0 after repeated start", 32'h5A, 32'(rb));
        bus_stop();
        hold(4);
        chk("R8 regs after repeated start", exp_regs, regs);

        // R7: after STOP, clocked bytes are ignored
        bus_start();
        put_byte(addr_byte(2'b10, 1'b0), ack);
        chk("R7 address ack", 1, 32'(ack));
        widx = 0;
        bus_stop();
        put_byte(8'h99, ack);
        chk("R7 no ack after stop", 0, 32'(ack));
        hold(4);
        chk("R7 regs unchanged after stop", exp_regs, regs);

        // R9: enable only moved while SCL low
        chk("R9 oe changes with SCL high", 0, 32'(viol));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule